// File: doc/BRIEF.md
# Drain-Source Overcurrent Supervisor

This block watches six per-switch overcurrent comparator bits that come from the analog sense of a three-phase half-bridge stage. Whenever the gate command of a switch goes from off to on, that switch's comparator is masked for a programmable blanking window, which hides the ringing of the turn-on edge. After the window, a trip has to stay asserted for a programmable persistence window before it counts as an event. A trip that drops out early is forgotten.

A 3-bit response code selects what an event does. The first option is a latched shutdown, which raises a force-all-gates-off line for the gate stage. The second only records and reports the event. The remaining codes mute detection entirely. Per-switch sticky flags, a fault-request line and a live OR of the confirmed trips are presented to the surrounding fault logic. A single-cycle clear request releases the latched state once every trip has gone away.

Timing is counted in clock cycles. One step unit is `CLK_PER_STEP` cycles: the default of 438 cycles is about 1.75 µs at 250 MHz. Both window codes select 0, 1, 2 or 4 step units.

Top module: `ocp_supervisor`

## Requirements
- R1: The six switch positions use one bit order on `gateCmd`, `cmpTrip` and `statusFlags`: bit 5 high A, bit 4 low A, bit 3 high B, bit 2 low B, bit 1 high C, bit 0 low C.
- R2: The blanking window starts in the cycle in which a switch's gate command rises. It lasts L cycles, with L = steps × `CLK_PER_STEP`. `blankCode` values 00, 01, 10 and 11 select 0, 1, 2 and 4 steps. That switch's comparator is ignored for the whole window.
- R3: A trip counts only if the comparator stays high for D+1 consecutive unblanked cycles. D = steps × `CLK_PER_STEP`, with `dglCode` 00, 01, 10 and 11 selecting 0, 1, 2 and 4 steps. A trip that is high for D cycles or fewer leaves no trace.
- R4: If the gate command and the comparator of a switch rise together and the comparator stays high, the flag of that switch is set after exactly L+D+1 rising clock edges. It is still clear after L+D edges.
- R5: With `modeCode` 000, a confirmed trip sets its flag, `faultReq` and `forceOff` on the next edge.
- R6: With `modeCode` 001, a confirmed trip sets its flag and `faultReq`, and `forceOff` stays low.
- R7: With `modeCode` 010 through 111, a comparator trip changes no flag, `liveStatus`, `faultReq` or `forceOff`.
- R8: Flags, `faultReq` and `forceOff` stay set until `clearPulse` is sampled high in a cycle in which no confirmed trip is active. A clear request made while a trip is still confirmed is ignored.
- R9: `liveStatus` is the registered OR of the confirmed trips in the monitoring modes. It is not latched, and it falls one edge after the trip ends, while the flags remain set.
- R10: A new rising gate command restarts the blanking window of that switch from the beginning, even while an earlier window is still running.
- R11: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateCmd | input | 6 | Per-switch gate-on command |
| cmpTrip | input | 6 | Per-switch overcurrent comparator output |
| blankCode | input | 2 | Blanking length select |
| dglCode | input | 2 | Persistence length select |
| modeCode | input | 3 | Response select (000 shutdown, 001 report, other values off) |
| clearPulse | input | 1 | Request to release latched state |
| statusFlags | output | 6 | Sticky per-switch event flags |
| liveStatus | output | 1 | Registered OR of the confirmed trips |
| faultReq | output | 1 | Sticky fault request |
| forceOff | output | 1 | Sticky force-all-gates-off |

## Verification
A blanking or persistence counter that is off by one shows up at the ports as a flag that rises one edge early or late, relative to the L+D+1 count. The bench therefore samples on both sides of that edge. A blanking timer that fails to reload on a second gate rise sets the flag about 20 cycles too early in the restart case. A clear gate that does not check for active trips drops the flags in the very cycle after the blocked clear. A wrong mode decode changes `forceOff` or the flags in the first edge after a trip is confirmed.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    RESP_SHUTDOWN,
    RESP_REPORT,
    RESP_OFF
  } respMode_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic       monEnable;
    logic [2:0] blankSteps;
    logic [2:0] dglSteps;
  } dpCtl_t;

  // window code to step-unit count: 0, 1, 2, 4
  function automatic logic [2:0] stepsOf(input logic [1:0] code);
    case (code)
      2'b00:   stepsOf = 3'd0;
      2'b01:   stepsOf = 3'd1;
      2'b10:   stepsOf = 3'd2;
      default: stepsOf = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ocp_datapath.sv
module ocp_datapath
  import ocp_pkg::*;
#(
  parameter int NUM_SW       = 6,
  parameter int CLK_PER_STEP = 438
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [NUM_SW-1:0] gateCmd,
  input  logic [NUM_SW-1:0] cmpTrip,
  output logic [NUM_SW-1:0] confirmed
);

  localparam int MAX_LEN = 4 * CLK_PER_STEP;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] blankLen;
  logic [CW-1:0] dglLen;
  logic [CW-1:0] blankLoad;

  assign blankLen  = CW'(ctl.blankSteps) * CW'(CLK_PER_STEP);
  assign dglLen    = CW'(ctl.dglSteps) * CW'(CLK_PER_STEP);
  // the rise cycle itself is the first blanked cycle
  assign blankLoad = (blankLen == '0) ? '0 : blankLen - 1'b1;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    logic          gatePrev;
    logic [CW-1:0] blankRemain;
    logic [CW-1:0] persistCnt;
    logic          rise;
    logic          blanking;
    logic          qualified;

    assign rise      = gateCmd[i] & ~gatePrev;
    assign blanking  = (rise && (blankLen != '0)) || (blankRemain != '0);
    assign qualified = cmpTrip[i] & ~blanking & ctl.monEnable;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        gatePrev    <= 1'b0;
        blankRemain <= '0;
        persistCnt  <= '0;
      end else begin
        gatePrev <= gateCmd[i];
        if (rise)
          blankRemain <= blankLoad;
        else if (blankRemain != '0)
          blankRemain <= blankRemain - 1'b1;

        if (!qualified)
          persistCnt <= '0;
        else if (persistCnt < dglLen)
          persistCnt <= persistCnt + 1'b1;
      end
    end

    assign confirmed[i] = qualified && (persistCnt >= dglLen);
  end

endmodule

// File: rtl/ocp_control.sv
module ocp_control
  import ocp_pkg::*;
#(
  parameter int NUM_SW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        blankCode,
  input  logic [1:0]        dglCode,
  input  logic [2:0]        modeCode,
  input  logic              clearPulse,
  input  logic [NUM_SW-1:0] confirmed,
  output dpCtl_t            ctl,
  output logic [NUM_SW-1:0] statusFlags,
  output logic              liveStatus,
  output logic              faultReq,
  output logic              forceOff
);

  respMode_t respMode;
  logic      anyConf;
  logic      clearGrant;

  always_comb begin
    case (modeCode)
      3'b000:  respMode = RESP_SHUTDOWN;
      3'b001:  respMode = RESP_REPORT;
      default: respMode = RESP_OFF;
    endcase
  end

  assign ctl.monEnable  = (respMode != RESP_OFF);
  assign ctl.blankSteps = stepsOf(blankCode);
  assign ctl.dglSteps   = stepsOf(dglCode);

  assign anyConf    = |confirmed;
  assign clearGrant = clearPulse & ~anyConf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusFlags <= '0;
      liveStatus  <= 1'b0;
      faultReq    <= 1'b0;
      forceOff    <= 1'b0;
    end else begin
      liveStatus <= anyConf & ctl.monEnable;
      if (clearGrant) begin
        statusFlags <= '0;
        faultReq    <= 1'b0;
        forceOff    <= 1'b0;
      end else if (ctl.monEnable) begin
        statusFlags <= statusFlags | confirmed;
        faultReq    <= faultReq | anyConf;
        forceOff    <= forceOff | (anyConf && (respMode == RESP_SHUTDOWN));
      end
    end
  end

endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
  import ocp_pkg::*;
#(
  parameter int NUM_SW       = 6,
  parameter int CLK_PER_STEP = 438
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SW-1:0] gateCmd,
  input  logic [NUM_SW-1:0] cmpTrip,
  input  logic [1:0]        blankCode,
  input  logic [1:0]        dglCode,
  input  logic [2:0]        modeCode,
  input  logic              clearPulse,
  output logic [NUM_SW-1:0] statusFlags,
  output logic              liveStatus,
  output logic              faultReq,
  output logic              forceOff
);

  dpCtl_t            ctl;
  logic [NUM_SW-1:0] confirmed;

  ocp_datapath #(
    .NUM_SW      (NUM_SW),
    .CLK_PER_STEP(CLK_PER_STEP)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .gateCmd  (gateCmd),
    .cmpTrip  (cmpTrip),
    .confirmed(confirmed)
  );

  ocp_control #(
    .NUM_SW(NUM_SW)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .blankCode  (blankCode),
    .dglCode    (dglCode),
    .modeCode   (modeCode),
    .clearPulse (clearPulse),
    .confirmed  (confirmed),
    .ctl        (ctl),
    .statusFlags(statusFlags),
    .liveStatus (liveStatus),
    .faultReq   (faultReq),
    .forceOff   (forceOff)
  );

endmodule

// File: rtl/ocp_supervisor_chk.sv
module ocp_supervisor_chk #(
  parameter int NUM_SW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_SW-1:0] gateCmd,
  input logic [1:0]        blankCode,
  input logic [2:0]        modeCode,
  input logic              clearPulse,
  input logic [NUM_SW-1:0] statusFlags,
  input logic              liveStatus,
  input logic              faultReq,
  input logic              forceOff
);

  logic [NUM_SW-1:0] gatePrevC;
  logic [NUM_SW-1:0] riseC;

  always_ff @(posedge clk) begin
    if (!rstN) gatePrevC <= '0;
    else       gatePrevC <= gateCmd;
  end

  assign riseC = gateCmd & ~gatePrevC;

  // R8: a flag may only drop after a clear request
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(statusFlags) & ~statusFlags) != '0) |-> $past(clearPulse)));

  // R5: the shutdown force only rises under the shutdown code
  assert_force_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(forceOff) |-> ($past(modeCode) == 3'b000)));

  // R5: a forced shutdown always comes with a fault request
  assert_force_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (forceOff |-> faultReq));

  // R9: a live trip always comes with a fault request
  assert_live_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    (liveStatus |-> faultReq));

  // R7: muted codes set nothing and show no live trip
  assert_muted_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(modeCode) >= 3'd2) |->
      (!liveStatus && ((statusFlags & ~$past(statusFlags)) == '0))));

  // R2: no flag is set for a switch whose gate rose in a blanked cycle
  assert_blank_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    (((riseC != '0) && (blankCode != 2'b00)) |=>
      ((statusFlags & ~$past(statusFlags) & $past(riseC)) == '0)));

endmodule

bind ocp_supervisor ocp_supervisor_chk #(.NUM_SW(NUM_SW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .gateCmd    (gateCmd),
  .blankCode  (blankCode),
  .modeCode   (modeCode),
  .clearPulse (clearPulse),
  .statusFlags(statusFlags),
  .liveStatus (liveStatus),
  .faultReq   (faultReq),
  .forceOff   (forceOff)
);

// File: tb/ocp_supervisor_tb.sv
module ocp_supervisor_tb_top;

  localparam int STEP = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] gateCmd;
  logic [5:0] cmpTrip;
  logic [1:0] blankCode;
  logic [1:0] dglCode;
  logic [2:0] modeCode;
  logic       clearPulse;
  logic [5:0] statusFlags;
  logic       liveStatus;
  logic       faultReq;
  logic       forceOff;

  always #2 clk = ~clk;  // 250 MHz

  ocp_supervisor #(.NUM_SW(6), .CLK_PER_STEP(STEP)) dut_i (
    .clk(clk), .rstN(rstN), .gateCmd(gateCmd), .cmpTrip(cmpTrip),
    .blankCode(blankCode), .dglCode(dglCode), .modeCode(modeCode),
    .clearPulse(clearPulse), .statusFlags(statusFlags),
    .liveStatus(liveStatus), .faultReq(faultReq), .forceOff(forceOff)
  );

  typedef struct {
    string      tag;
    logic [5:0] flags;
    logic       live;
    logic       fault;
    logic       frc;
  } exp_t;

  exp_t expQ[$];
  int   nCompared = 0;
  int   nMismatch = 0;
  bit   finished  = 0;

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string tag, input logic [5:0] f,
                           input logic l, input logic fl, input logic fo);
    exp_t e;
    e.tag = tag; e.flags = f; e.live = l; e.fault = fl; e.frc = fo;
    expQ.push_back(e);
  endtask

  task automatic cleanUp();
    gateCmd = '0; cmpTrip = '0; clearPulse = 1'b1;
    waitCyc(1);
    clearPulse = 1'b0;
    waitCyc(1);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nCompared++;
        if (statusFlags !== e.flags || liveStatus !== e.live ||
            faultReq !== e.fault || forceOff !== e.frc) begin
          nMismatch++;
          $display("FAIL %s: got flags=%b live=%b fault=%b force=%b, expected flags=%b live=%b fault=%b force=%b",
                   e.tag, statusFlags, liveStatus, faultReq, forceOff,
                   e.flags, e.live, e.fault, e.frc);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      nCompared++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; gateCmd = '0; cmpTrip = '0; clearPulse = 1'b0;
    blankCode = 2'b01; dglCode = 2'b10; modeCode = 3'b000;
    waitCyc(3);
    expectOut("R11 reset", 6'b0, 0, 0, 0);
    waitCyc(1);
    rstN = 1'b1;
    waitCyc(2);

    // R4/R5/R1: L=8, D=16, high A (bit 5), flag after L+D+1 = 25 edges
    gateCmd[5] = 1'b1; cmpTrip[5] = 1'b1;
    waitCyc(24);
    expectOut("R4 edge L+D", 6'b0, 0, 0, 0);
    waitCyc(1);
    expectOut("R4 R5 R1 edge L+D+1", 6'b100000, 1, 1, 1);

    // R8: clear is ignored while the trip is still confirmed
    clearPulse = 1'b1; waitCyc(1); clearPulse = 1'b0;
    expectOut("R8 blocked clear", 6'b100000, 1, 1, 1);

    // R9: live status falls, flags remain
    cmpTrip[5] = 1'b0;
    waitCyc(1);
    expectOut("R9 live drop", 6'b100000, 0, 1, 1);
    clearPulse = 1'b1; waitCyc(1); clearPulse = 1'b0;
    expectOut("R8 clear granted", 6'b0, 0, 0, 0);
    cleanUp();

    // R3: trip high for D cycles is discarded, low C (bit 0)
    gateCmd[0] = 1'b1;
    waitCyc(12);
    cmpTrip[0] = 1'b1;
    waitCyc(16);
    cmpTrip[0] = 1'b0;
    waitCyc(3);
    expectOut("R3 short trip discarded", 6'b0, 0, 0, 0);
    // R3: D+1 cycles is accepted
    cmpTrip[0] = 1'b1;
    waitCyc(17);
    cmpTrip[0] = 1'b0;
    waitCyc(1);
    expectOut("R3 D+1 trip accepted", 6'b000001, 0, 1, 1);
    cleanUp();

    // R2/R1: no blanking, no persistence; high B and low B together
    blankCode = 2'b00; dglCode = 2'b00;
    gateCmd[3] = 1'b1; cmpTrip[3] = 1'b1;
    gateCmd[2] = 1'b1; cmpTrip[2] = 1'b1;
    expectOut("R2 before first edge", 6'b0, 0, 0, 0);
    waitCyc(1);
    expectOut("R2 R1 zero windows", 6'b001100, 1, 1, 1);
    cleanUp();

    // R10: restart of blanking, L=32, D=0, high C (bit 1)
    blankCode = 2'b11; dglCode = 2'b00;
    gateCmd[1] = 1'b1; cmpTrip[1] = 1'b1;
    waitCyc(20);
    gateCmd[1] = 1'b0;
    waitCyc(1);
    gateCmd[1] = 1'b1;
    waitCyc(32);
    expectOut("R10 still blanked after restart", 6'b0, 0, 0, 0);
    waitCyc(1);
    expectOut("R10 flag after restarted window", 6'b000010, 1, 1, 1);
    cleanUp();

    // R6: report only, low A (bit 4)
    blankCode = 2'b00; dglCode = 2'b00; modeCode = 3'b001;
    gateCmd[4] = 1'b1; cmpTrip[4] = 1'b1;
    waitCyc(1);
    expectOut("R6 report only", 6'b010000, 1, 1, 0);
    cleanUp();

    // R7: muted codes 010 and 111
    modeCode = 3'b010;
    gateCmd[5] = 1'b1; cmpTrip[5] = 1'b1;
    waitCyc(3);
    expectOut("R7 code 010 muted", 6'b0, 0, 0, 0);
    gateCmd[5] = 1'b0; waitCyc(1);
    modeCode = 3'b111;
    gateCmd[5] = 1'b1;
    waitCyc(3);
    expectOut("R7 code 111 muted", 6'b0, 0, 0, 0);
    // back to shutdown with trip still high: detected
    modeCode = 3'b000;
    waitCyc(1);
    expectOut("R5 resume after mute", 6'b100000, 1, 1, 1);
    cleanUp();
    expectOut("R8 final clear", 6'b0, 0, 0, 0);

    waitCyc(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule